// File: doc/BRIEF.md
# Program Memory Pointer Access Unit

This block keeps a 16-bit byte pointer into a program memory made of 16-bit words and carries out three operations through it. A byte read returns one half of the addressed word. A second form of the byte read also steps the pointer forward by one. A word store writes a whole 16-bit word and steps the pointer forward by two. The memory is a small internal array with a parameterised depth. The pointer can be loaded directly from a separate port.

A caller loads the pointer once. It then issues a stream of reads or stores, and the automatic stepping walks the pointer through the memory. Read data comes back one clock after the request, because the memory read is synchronous. A store from an odd byte address is refused, and a one-cycle error pulse reports the refusal.

Top module: `pgm_ptr_unit`

## Requirements
- R1: After reset, `ptr_q` is 0x0000, `rd_valid` and `err` are 0, and every memory word reads as 0x0000.
- R2: A byte read (`op_code` 0 or 1) addresses word `ptr_q[AW:1]`, with AW = log2(DEPTH) and DEPTH a power of two. Pointer bits above AW are ignored. `ptr_q[0]` = 0 returns bits [7:0] of the word and `ptr_q[0]` = 1 returns bits [15:8].
- R3: A read with `op_code` 1 uses the pointer value from before the step and then adds 1 to the pointer. The new value shows on `ptr_q` after the edge.
- R4: A read with `op_code` 0 leaves the pointer unchanged.
- R5: A store (`op_code` 2) with `ptr_q[0]` = 0 writes `wdata` into word `ptr_q[AW:1]` and adds 2 to the pointer.
- R6: A store with `ptr_q[0]` = 1 does not change memory and does not change the pointer. It raises `err` for exactly one cycle.
- R7: Pointer steps wrap modulo 2^16. Stepping 0xFFFF by 1 gives 0x0000, and stepping 0xFFFE by 2 gives 0x0000.
- R8: `rd_valid` is high for exactly the one cycle after an accepted read strobe, together with the new `rd_byte`. At all other times `rd_byte` holds its last value.
- R9: When `ptr_load` is high, `ptr_q` takes `ptr_din`, and any operation strobed in the same cycle is ignored: no memory write, no `rd_valid`, no `err`.
- R10: `op_code` 3 is reserved. It has no effect on the pointer, the memory or the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 2 | 0 read, 1 read with step, 2 word store, 3 reserved |
| wdata | input | 16 | Word to store |
| ptr_load | input | 1 | Load the pointer from `ptr_din` |
| ptr_din | input | 16 | New pointer value |
| rd_byte | output | 8 | Byte returned by the last read |
| rd_valid | output | 1 | `rd_byte` was updated this cycle |
| ptr_q | output | 16 | Current pointer |
| err | output | 1 | A misaligned store was refused |

## Verification
The hardest situations to reach are the ones at the edges of the pointer's range. One is the wrap at the top of the 16-bit space, where the pointer passes 0xFFFF or 0xFFFE. The other is a store refused at an odd address, followed by a check that the word was really left intact. Random stepping almost never reaches either, so directed sequences load the pointer to 0xFFFE and 0xFFFF, store and read across the wrap, and read back the refused word. Random loads with high pointer bits set exercise the aliasing of the word index. Loads that collide with operation strobes check the priority rule.

// File: rtl/pgm_ptr_unit.sv
module pgm_ptr_unit #(
  parameter int DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_valid,
  input  logic [1:0]  op_code,
  input  logic [15:0] wdata,
  input  logic        ptr_load,
  input  logic [15:0] ptr_din,
  output logic [7:0]  rd_byte,
  output logic        rd_valid,
  output logic [15:0] ptr_q,
  output logic        err
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [1:0] OP_RD = 2'd0, OP_RDI = 2'd1, OP_ST = 2'd2;

  logic [15:0] mem [DEPTH];

  wire [AW-1:0] widx  = ptr_q[AW:1];
  wire          do_op = op_valid & ~ptr_load;
  wire          is_rd = do_op & ((op_code == OP_RD) | (op_code == OP_RDI));
  wire          is_st = do_op & (op_code == OP_ST);
  wire          st_ok = is_st & ~ptr_q[0];
  wire [15:0]   cur   = mem[widx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q    <= 16'h0000;
      rd_byte  <= 8'h00;
      rd_valid <= 1'b0;
      err      <= 1'b0;
    end else begin
      rd_valid <= is_rd;
      err      <= is_st & ptr_q[0];
      if (is_rd) rd_byte <= ptr_q[0] ? cur[15:8] : cur[7:0];
      if (ptr_load)                      ptr_q <= ptr_din;
      else if (is_rd && op_code == OP_RDI) ptr_q <= ptr_q + 16'd1;
      else if (st_ok)                      ptr_q <= ptr_q + 16'd2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 16'h0000;
    end else if (st_ok) begin
      mem[widx] <= wdata;
    end
  end

  p_step_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !ptr_load && op_code == OP_RDI) |=> ptr_q == $past(ptr_q) + 16'd1);
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !ptr_load && op_code == OP_RD) |=> $stable(ptr_q));
  p_step_two_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !ptr_load && op_code == OP_ST && !ptr_q[0]) |=> ptr_q == $past(ptr_q) + 16'd2);
  p_refuse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !ptr_load && op_code == OP_ST && ptr_q[0]) |=> err && $stable(ptr_q));
  p_err_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(op_valid && !ptr_load && op_code == OP_ST && ptr_q[0]));
  p_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> $stable(rd_byte));
  p_load_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_load |=> ptr_q == $past(ptr_din) && !rd_valid && !err);
  p_reserved_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !ptr_load && op_code == 2'd3) |=> $stable(ptr_q) && !rd_valid && !err);
endmodule

// File: tb/pgm_ptr_unit_tb.sv
`timescale 1ns/1ps
module pgm_ptr_unit_tb;
  localparam int DEPTH = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic op_valid = 1'b0, ptr_load = 1'b0;
  logic [1:0] op_code = 2'd0;
  logic [15:0] wdata = 16'h0, ptr_din = 16'h0;
  logic [7:0] rd_byte;
  logic rd_valid, err;
  logic [15:0] ptr_q;

  int n_cmp = 0, n_bad = 0;
  logic [15:0] m_mem [DEPTH];
  logic [15:0] m_ptr = 16'h0;
  logic [7:0]  m_byte = 8'h0;

  always #4 clk = ~clk;

  pgm_ptr_unit #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .wdata(wdata), .ptr_load(ptr_load), .ptr_din(ptr_din),
    .rd_byte(rd_byte), .rd_valid(rd_valid), .ptr_q(ptr_q), .err(err));

  function automatic int widx(input logic [15:0] p);
    return (p >> 1) % DEPTH;
  endfunction

  task automatic cmp(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic step(input logic ld, input logic [15:0] ldv, input logic v,
                      input logic [1:0] c, input logic [15:0] wd, input string tag);
    logic exp_v, exp_e;
    @(negedge clk);
    ptr_load = ld; ptr_din = ldv; op_valid = v; op_code = c; wdata = wd;
    exp_v = 1'b0; exp_e = 1'b0;
    if (ld) m_ptr = ldv;
    else if (v) begin
      case (c)
        2'd0, 2'd1: begin
          m_byte = m_ptr[0] ? m_mem[widx(m_ptr)][15:8] : m_mem[widx(m_ptr)][7:0];
          exp_v = 1'b1;
          if (c == 2'd1) m_ptr = m_ptr + 16'd1;
        end
        2'd2: if (m_ptr[0]) exp_e = 1'b1;
              else begin m_mem[widx(m_ptr)] = wd; m_ptr = m_ptr + 16'd2; end
        default: ;
      endcase
    end
    @(negedge clk);
    ptr_load = 1'b0; op_valid = 1'b0;
    cmp({tag, " ptr"}, ptr_q, m_ptr);
    cmp({tag, " valid"}, {15'd0, rd_valid}, {15'd0, exp_v});
    cmp({tag, " err"}, {15'd0, err}, {15'd0, exp_e});
    cmp({tag, " byte"}, {8'd0, rd_byte}, {8'd0, m_byte});
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    int seed;
    for (int i = 0; i < DEPTH; i++) m_mem[i] = 16'h0;
    seed = 7;
    void'($urandom(seed));
    #20 rst_n = 1'b1;
    @(negedge clk);
    cmp("R1 reset ptr", ptr_q, 16'h0);
    cmp("R1 reset valid/err", {14'd0, rd_valid, err}, 16'h0);
    step(0, 0, 1, 2'd1, 0, "R1 zero mem");
    // R5/R2: store then read both halves
    step(1, 16'h0010, 0, 0, 0, "R9 load");
    step(0, 0, 1, 2'd2, 16'hA55A, "R5 store");
    step(1, 16'h0010, 0, 0, 0, "R9 load");
    step(0, 0, 1, 2'd1, 0, "R3 low byte");
    step(0, 0, 1, 2'd0, 0, "R2 high byte");
    step(0, 0, 1, 2'd0, 0, "R4 no step");
    // R6: misaligned store refused, word intact
    step(0, 0, 1, 2'd2, 16'h1234, "R6 refuse");
    step(0, 0, 0, 0, 0, "R8 idle hold");
    step(1, 16'h0010, 0, 0, 0, "R9 load");
    step(0, 0, 1, 2'd1, 0, "R6 intact lo");
    step(0, 0, 1, 2'd1, 0, "R6 intact hi");
    // R7: wrap
    step(1, 16'hFFFE, 0, 0, 0, "R9 load");
    step(0, 0, 1, 2'd2, 16'hBEEF, "R7 store wrap");
    step(1, 16'hFFFF, 0, 0, 0, "R9 load");
    step(0, 0, 1, 2'd1, 0, "R7 read wrap");
    // R2: high bits alias
    step(1, 16'h8010, 0, 0, 0, "R9 load");
    step(0, 0, 1, 2'd0, 0, "R2 alias");
    // R9: collision, R10 reserved
    step(1, 16'h0020, 1, 2'd2, 16'h7777, "R9 collide store");
    step(1, 16'h0021, 1, 2'd1, 0, "R9 collide read");
    step(0, 0, 1, 2'd3, 16'h9999, "R10 reserved");
    step(1, 16'h0020, 0, 0, 0, "R9 load");
    step(0, 0, 1, 2'd0, 0, "R10 mem intact");
    for (int k = 0; k < 3000; k++) begin
      logic [3:0] r;
      r = 4'($urandom % 16);
      if (r == 0)
        step(1, 16'($urandom), 0, 0, 0, "R9 rnd load");
      else if (r == 1)
        step(1, 16'($urandom), 1, 2'($urandom), 16'($urandom), "R9 rnd collide");
      else
        step(0, 0, r[3] | r[2], 2'($urandom), 16'($urandom), "R2 rnd op");
    end
    finish_run();
  end
endmodule